// File: doc/BRIEF.md
# I2C-over-AUX Display-ID Responder

This block answers display-identification requests that a host driver sends as I2C transactions carried over an auxiliary display channel. It does not drive any wire. The host writes a request word into a data register and then writes a control word with the send-busy bit set. In that same clock edge the block decodes the request, updates its target-selection state and writes a finished reply back into the control register and the first data register. The host can read that reply on the next cycle.

A 128-byte identification table sits behind the responder and is filled through a separate byte write port. An address-only request of length 3 opens or closes a transaction. If the middle-of-transaction flag is set and the address is 0x50, the target is selected, and the table becomes readable when a monitor is present. A read request of length 4 returns one table byte and moves the read pointer on by one. Write requests are acknowledged and have no other effect.

Top module: `aux_edid_responder`

## Requirements
- R1: After reset the control register and all five data registers read 0. No target is selected and the read pointer is 0.
- R2: A host write to a data register (offsets 0x14, 0x18, 0x1C, 0x20, 0x24) stores the full 32-bit value, which reads back from the same offset. Reads of any other offset apart from the control register (0x10) return 0.
- R3: A write to the control register with bit 31 (send-busy) clear changes neither the registers nor the selection state.
- R4: On a send, the request is taken from the first data register (0x14): I2C address in bits 23:8, opcode in bits 31:28. The control register then reads bit 30 (done) set, with a reply size in bits 24:20 of 2 if opcode bit 0 (word bit 28, read) is set and 1 if it is clear. All other control bits read 0.
- R5: A send whose message length (control write bits 24:20) is 3 and whose opcode bit 2 (word bit 30, middle-of-transaction) is clear acts as a stop. It deselects the target, marks the table unavailable and zeroes the read pointer.
- R6: A length-3 send with middle-of-transaction set and address 0x50 selects the target. It makes the table available if the monitor_present input is 1 in that cycle. Availability is never set without selection.
- R7: A length-3 send with middle-of-transaction set and address 0 acts like a stop. Any other address leaves the selection state unchanged.
- R8: A length-4 read send with the target selected and the table available writes the table byte at the read pointer into bits 23:16 of the first data register, with all other bits 0. It then moves the pointer on by one.
- R9: A length-4 read send with no target selected, or with the table unavailable, writes 0x00FF0000 into the first data register.
- R10: Every send that is not a rejected read writes the ACK code 0 into bits 31:24 of the first data register. A write request (opcode bit 0 clear) of any length other than 3 only writes 0x00000000 there, and the pointer and selection stay as they were.
- R11: A read send whose length is neither 3 nor 4 leaves the first data register unchanged. The control register is still updated as in R4.
- R12: Once the read pointer has reached 128, a read returns byte 0 (data word 0x00000000) and the pointer does not move.
- R13: A byte written through the table write port, at a 7-bit address, is returned by a later read whose pointer equals that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 8 | Host register offset, used for both writes and reads |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| rom_we | input | 1 | Identification table byte write enable |
| rom_waddr | input | 7 | Identification table write address |
| rom_wdata | input | 8 | Identification table write byte |
| monitor_present | input | 1 | A monitor is attached, sampled when the target is selected |

## Verification
The bench uses the default parameters: a 128-entry table and five data registers. At this size the pointer can be walked through every table entry and onto the 128 limit in a few hundred cycles, so the saturation case is reached, not just assumed. Selection is tried with the monitor absent and then present. Stop by length-3 request and stop by address 0 are both exercised, and so are the reject path for lengths other than 3 and 4 and the write-request path, each followed by reads that show the pointer did not move.

// File: rtl/aux_edid_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the AUX display-ID responder.
// Assumes a byte-addressed register window with 32-bit registers.
package aux_edid_pkg;
    localparam int          LEN_W      = 5;
    localparam logic [7:0]  CTRL_OFS   = 8'h10;
    localparam logic [7:0]  DATA_BASE  = 8'h14;
    localparam int          BUSY_BIT   = 31;
    localparam int          DONE_BIT   = 30;
    localparam int          SIZE_LSB   = 20;
    localparam int          READ_BIT   = 28;
    localparam int          MOT_BIT    = 30;
    localparam logic [15:0] TARGET_ID  = 16'h0050;
    localparam logic [7:0]  ACK_CODE   = 8'h00;
    localparam logic [7:0]  MISS_BYTE  = 8'hFF;

    typedef enum logic [2:0] {
        ACT_ACK,
        ACT_RESET,
        ACT_SELECT,
        ACT_READ_HIT,
        ACT_READ_MISS,
        ACT_REJECT
    } act_e;
endpackage

// File: rtl/aux_edid_rom.sv
`timescale 1ns/1ps
// Identification table storage: one byte write port, one asynchronous
// read port indexed by a pointer one bit wider than the address, so that
// pointers at or past DEPTH read as zero. Assumes DEPTH is a power of two.
module aux_edid_rom #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW:0]   rd_ptr,
    output logic [7:0]    rd_byte
);
    logic [7:0] mem [DEPTH];

    // Store one table byte per write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Return the addressed byte, or zero beyond the table.
    always_comb begin
        if (rd_ptr < (AW+1)'(DEPTH)) rd_byte = mem[rd_ptr[AW-1:0]];
        else                         rd_byte = 8'h00;
    end
endmodule

// File: rtl/aux_edid_decode.sv
`timescale 1ns/1ps
// Request decoder: classifies a send from its length, opcode bits, I2C
// address and the current selection. Purely combinational; the result is
// only meaningful in a cycle where a send is presented.
module aux_edid_decode
    import aux_edid_pkg::*;
(
    input  logic [LEN_W-1:0] msg_len,
    input  logic             is_read,
    input  logic             mot,
    input  logic [15:0]      i2c_addr,
    input  logic             sel,
    input  logic             avail,
    output act_e             act,
    output logic [LEN_W-1:0] reply_size
);
    // Reply size follows the read/write direction only.
    always_comb reply_size = is_read ? LEN_W'(2) : LEN_W'(1);

    // Pick the action for this request.
    always_comb begin
        if (msg_len == LEN_W'(3)) begin
            if (!mot)                       act = ACT_RESET;
            else if (i2c_addr == 16'h0000)  act = ACT_RESET;
            else if (i2c_addr == TARGET_ID) act = ACT_SELECT;
            else                            act = ACT_ACK;
        end else if (!is_read) begin
            act = ACT_ACK;
        end else if (msg_len != LEN_W'(4)) begin
            act = ACT_REJECT;
        end else if (sel && avail) begin
            act = ACT_READ_HIT;
        end else begin
            act = ACT_READ_MISS;
        end
    end
endmodule

// File: rtl/aux_edid_select.sv
`timescale 1ns/1ps
// Selection state: target-selected flag, table-available flag and the
// read pointer. Updated only on the cycle a send is accepted (go).
// Availability accumulates across selects until a reset action.
module aux_edid_select
    import aux_edid_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  act_e        act,
    input  logic        monitor_present,
    output logic        sel_q,
    output logic        avail_q,
    output logic [AW:0] ptr_q
);
    // Track selection and advance the pointer on table hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            avail_q <= 1'b0;
            ptr_q   <= '0;
        end else if (go) begin
            case (act)
                ACT_RESET: begin
                    sel_q   <= 1'b0;
                    avail_q <= 1'b0;
                    ptr_q   <= '0;
                end
                ACT_SELECT: begin
                    sel_q   <= 1'b1;
                    avail_q <= avail_q | monitor_present;
                end
                ACT_READ_HIT: begin
                    if (ptr_q < (AW+1)'(DEPTH)) ptr_q <= ptr_q + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/aux_edid_responder.sv
`timescale 1ns/1ps
// Top of the AUX display-ID responder. Holds the control register and
// N_DATA data registers, turns a control write with send-busy into an
// immediate reply, and wires the decoder, selection state and table.
// Assumes the host writes the request word before each send.
module aux_edid_responder
    import aux_edid_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int N_DATA = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        rom_we,
    input  logic [6:0]  rom_waddr,
    input  logic [7:0]  rom_wdata,
    input  logic        monitor_present
);
    localparam int AW = $clog2(DEPTH);

    function automatic logic [7:0] data_ofs(input int idx);
        return 8'(DATA_BASE + 8'(4 * idx));
    endfunction

    logic [31:0]      ctrl_q;
    logic [31:0]      data_q [N_DATA];
    logic [31:0]      first_data;
    logic             send;
    logic [LEN_W-1:0] send_len;
    logic             is_read;
    act_e             act;
    logic [LEN_W-1:0] reply_size;
    logic             sel_q, avail_q;
    logic [AW:0]      ptr_q;
    logic [7:0]       tbl_byte;
    logic [31:0]      reply_word;
    logic             reply_we;

    assign first_data = data_q[0];
    assign send       = reg_wr && (reg_addr == CTRL_OFS) && reg_wdata[BUSY_BIT];
    assign send_len   = reg_wdata[SIZE_LSB +: LEN_W];
    assign is_read    = first_data[READ_BIT];

    aux_edid_decode u_dec (
        .msg_len    (send_len),
        .is_read    (is_read),
        .mot        (first_data[MOT_BIT]),
        .i2c_addr   (first_data[23:8]),
        .sel        (sel_q),
        .avail      (avail_q),
        .act        (act),
        .reply_size (reply_size)
    );

    aux_edid_select #(.DEPTH(DEPTH)) u_sel (
        .clk             (clk),
        .rst_n           (rst_n),
        .go              (send),
        .act             (act),
        .monitor_present (monitor_present),
        .sel_q           (sel_q),
        .avail_q         (avail_q),
        .ptr_q           (ptr_q)
    );

    aux_edid_rom #(.DEPTH(DEPTH)) u_rom (
        .clk     (clk),
        .we      (rom_we),
        .waddr   (rom_waddr[AW-1:0]),
        .wdata   (rom_wdata),
        .rd_ptr  (ptr_q),
        .rd_byte (tbl_byte)
    );

    // Form the reply word for the first data register.
    always_comb begin
        reply_we = 1'b1;
        case (act)
            ACT_READ_HIT:  reply_word = {ACK_CODE, tbl_byte, 16'h0000};
            ACT_READ_MISS: reply_word = {ACK_CODE, MISS_BYTE, 16'h0000};
            ACT_REJECT: begin
                reply_word = '0;
                reply_we   = 1'b0;
            end
            default:       reply_word = {ACK_CODE, 24'h000000};
        endcase
    end

    // Control register: loaded with done and reply size on each send.
    always_ff @(posedge clk) begin
        if (!rst_n)    ctrl_q <= '0;
        else if (send) ctrl_q <= (32'd1 << DONE_BIT) |
                                 (32'(reply_size) << SIZE_LSB);
    end

    for (genvar gi = 0; gi < N_DATA; gi++) begin : g_data
        localparam logic [7:0] OFS = data_ofs(gi);
        if (gi == 0) begin : g_first
            // First data register: host store, or reply on a send.
            always_ff @(posedge clk) begin
                if (!rst_n)                          data_q[gi] <= '0;
                else if (reg_wr && reg_addr == OFS)  data_q[gi] <= reg_wdata;
                else if (send && reply_we)           data_q[gi] <= reply_word;
            end
        end else begin : g_rest
            // Remaining data registers: plain host store.
            always_ff @(posedge clk) begin
                if (!rst_n)                          data_q[gi] <= '0;
                else if (reg_wr && reg_addr == OFS)  data_q[gi] <= reg_wdata;
            end
        end
    end

    // Host read mux over the register window.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_OFS) reg_rdata = ctrl_q;
        for (int i = 0; i < N_DATA; i++) begin
            if (reg_addr == data_ofs(i)) reg_rdata = data_q[i];
        end
    end
endmodule

// File: rtl/aux_edid_checker.sv
`timescale 1ns/1ps
// Property checker for the responder, attached by bind. Observes the
// send strobe, the reply registers and the selection state.
module aux_edid_checker #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        send,
    input logic [4:0]  send_len,
    input logic        is_read,
    input logic [31:0] ctrl_q,
    input logic [31:0] data0,
    input logic        sel,
    input logic        avail,
    input logic [AW:0] ptr
);
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !send |=> $stable(ctrl_q));                                          // R3
    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        send |=> ctrl_q[30]);                                                // R4
    AST_MISS_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (send && is_read && send_len == 5'd4 && !(sel && avail))
        |=> data0 == 32'h00FF0000);                                          // R9
    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (send && is_read && send_len != 5'd4 && send_len != 5'd3)
        |=> $stable(data0));                                                 // R11
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr) && ptr != '0) |-> ptr == $past(ptr) + 1'b1);      // R8
    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= (AW+1)'(DEPTH));                                              // R12
    AST_AVAIL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        avail |-> sel);                                                      // R6
endmodule

bind aux_edid_responder aux_edid_checker #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .send     (send),
    .send_len (send_len),
    .is_read  (is_read),
    .ctrl_q   (ctrl_q),
    .data0    (first_data),
    .sel      (sel_q),
    .avail    (avail_q),
    .ptr      (ptr_q)
);

// File: tb/aux_edid_responder_tb.sv
`timescale 1ns/1ps
module aux_edid_responder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rom_we = 1'b0;
    logic [6:0]  rom_waddr = '0;
    logic [7:0]  rom_wdata = '0;
    logic        monitor_present = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    // Behavioural reference state.
    logic [31:0] m_reg [6];
    logic [7:0]  m_rom [128];
    bit          m_sel, m_avail;
    int          m_ptr;

    always #2.5 clk = ~clk;

    aux_edid_responder dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rom_we(rom_we),
        .rom_waddr(rom_waddr), .rom_wdata(rom_wdata),
        .monitor_present(monitor_present)
    );

    function automatic logic [7:0] tbl(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // Compare every register against the model.
    task automatic sweep(input string tag);
        logic [31:0] v;
        for (int i = 0; i < 6; i++) begin
            peek(8'(8'h10 + 4 * i), v);
            chk(v, m_reg[i], tag);
        end
        peek(8'h0C, v);
        chk(v, 32'h0, tag);
    endtask

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        int          len;
        logic [31:0] msg;
        logic [15:0] ad;
        bit          rd, mot;
        if (a >= 8'h14 && a <= 8'h24 && a[1:0] == 2'b00) begin
            m_reg[(a - 8'h10) / 4] = d;
        end else if (a == 8'h10 && d[31]) begin
            len = int'(d[24:20]);
            msg = m_reg[1];
            ad  = msg[23:8];
            rd  = msg[28];
            mot = msg[30];
            m_reg[0] = 32'h4000_0000 | ((rd ? 32'd2 : 32'd1) << 20);
            if (len == 3) begin
                if (!mot || ad == 16'h0) begin
                    m_sel = 0; m_avail = 0; m_ptr = 0;
                end else if (ad == 16'h0050) begin
                    m_sel = 1; m_avail = m_avail || monitor_present;
                end
                m_reg[1] = 32'h0;
            end else if (!rd) begin
                m_reg[1] = 32'h0;
            end else if (len == 4) begin
                if (m_sel && m_avail) begin
                    if (m_ptr < 128) begin
                        m_reg[1] = {8'h00, m_rom[m_ptr], 16'h0};
                        m_ptr++;
                    end else m_reg[1] = 32'h0;
                end else m_reg[1] = 32'h00FF_0000;
            end
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(a, d);
    endtask

    // Load the request word, then send with the given length.
    task automatic request(input logic [7:0] cb, input logic [15:0] ad, input int len, input string tag);
        wr(8'h14, {cb, ad, 8'h00});
        wr(8'h10, 32'h8000_0000 | (32'(len) << 20));
        sweep(tag);
    endtask

    task automatic read_byte(input logic [31:0] exp, input string tag);
        logic [31:0] v;
        request(8'h50, 16'h0000, 4, tag);
        peek(8'h14, v);
        chk(v, exp, tag);
    endtask

    initial begin
        #1_000_000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 6; i++) m_reg[i] = '0;
        m_sel = 0; m_avail = 0; m_ptr = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        sweep("R1");

        // Unselected read reports miss; reply size 2.
        read_byte(32'h00FF_0000, "R9");
        peek(8'h10, v); chk(v, 32'h4020_0000, "R4");

        // Data register stores.
        for (int i = 0; i < 5; i++) wr(8'(8'h14 + 4 * i), 32'hA5A5_0000 + 32'(i * 32'h1111));
        sweep("R2");

        // Control write without send-busy.
        wr(8'h10, 32'h7FFF_FFFF);
        sweep("R3");

        // Table load.
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            rom_we = 1'b1; rom_waddr = 7'(i); rom_wdata = tbl(i);
            m_rom[i] = tbl(i);
        end
        @(negedge clk); rom_we = 1'b0;

        // Select without a monitor: still a miss.
        monitor_present = 1'b0;
        request(8'h40, 16'h0050, 3, "R10");
        peek(8'h10, v); chk(v, 32'h4010_0000, "R4");
        read_byte(32'h00FF_0000, "R6");

        // Select with a monitor: table reads.
        monitor_present = 1'b1;
        request(8'h40, 16'h0050, 3, "R6");
        read_byte({8'h00, tbl(0), 16'h0}, "R8");
        read_byte({8'h00, tbl(1), 16'h0}, "R13");

        // Read of length 2 is rejected.
        request(8'h50, 16'h1234, 2, "R11");
        peek(8'h14, v); chk(v, 32'h5012_3400, "R11");
        peek(8'h10, v); chk(v, 32'h4020_0000, "R11");

        // Write request: ACK only, pointer kept.
        request(8'h40, 16'h0050, 4, "R10");
        peek(8'h14, v); chk(v, 32'h0, "R10");
        read_byte({8'h00, tbl(2), 16'h0}, "R10");

        // Other address with MOT: selection kept.
        request(8'h40, 16'h0037, 3, "R7");
        read_byte({8'h00, tbl(3), 16'h0}, "R7");

        // Walk to the end and past it.
        for (int i = 4; i < 128; i++) read_byte({8'h00, tbl(i), 16'h0}, "R13");
        read_byte(32'h0, "R12");
        read_byte(32'h0, "R12");

        // Stop closes the transaction.
        request(8'h00, 16'h0000, 3, "R5");
        read_byte(32'h00FF_0000, "R5");

        // Reselect starts at byte 0; address 0 clears selection.
        request(8'h40, 16'h0050, 3, "R6");
        read_byte({8'h00, tbl(0), 16'h0}, "R5");
        request(8'h40, 16'h0000, 3, "R7");
        read_byte(32'h00FF_0000, "R7");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule